// File: doc/BRIEF.md
# Half-Warp Global Memory Coalescer

The block takes one memory request from a group of sixteen threads and turns it into the shortest list of memory transactions it can. Each thread brings an active bit and a byte address. One element-size code is shared by all threads in the request. Each transaction the block emits has three parts: an aligned base address, a size of 32, 64 or 128 bytes, and a mask of the threads it serves. When every active thread has been served, the block pulses `done`. It moves no data. It only plans the transactions.

Each transaction is built around the lowest-numbered thread that is still waiting. The element size sets the width of the segment. Every waiting thread whose address falls inside that segment rides along in the same transaction. The transaction is then narrowed, at most twice, while the element footprints of its threads sit entirely in one half of the current window. A request is accepted on a valid/ready port. Transactions leave on a second valid/ready port, at most one per clock.

Top module: `halfwarp_coalescer`

## Requirements
- R1: The segment size follows the element-size code `req_esize`: code 0 (1-byte elements) gives 32 bytes, code 1 (2 bytes) gives 64 bytes, and codes 2, 3 and 4 (4, 8 and 16 bytes) give 128 bytes. `txn_bytes` is always 32, 64 or 128 and never exceeds the segment size.
- R2: The segment of each transaction is the one, aligned to the segment size, that contains the address of the lowest-numbered thread still waiting. `txn_base` is a multiple of `txn_bytes`.
- R3: `txn_mask` holds exactly those waiting threads whose address lies in the chosen segment. Those threads are then no longer waiting, so each active thread is served exactly once and inactive threads never appear in any mask.
- R4: A 128-byte segment whose member footprints all lie in one 64-byte half shrinks to 64 bytes, with the base placed on that half.
- R5: A 64-byte window, whether it is the original segment or the result of R4, shrinks to the 32-byte half that holds all member footprints, when one such half exists.
- R6: A thread's footprint covers its address through its address plus the element byte count minus one. A footprint that reaches into the upper half of a window counts as using that half, which can block a shrink.
- R7: Transactions follow one another until no active thread is left, with leaders in ascending thread order. `done` is high for exactly one cycle, the cycle after the final transaction handshake.
- R8: A request with no active threads produces no transaction, and `done` pulses in the cycle after that request is accepted.
- R9: While `txn_valid` is high and `txn_ready` is low, `txn_valid`, `txn_base`, `txn_bytes` and `txn_mask` hold their values into the next cycle. At most one transaction is handed over per clock.
- R10: `req_ready` is high only while no request is in progress. A request offered while the block is busy is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_active | input | NTHR | Per-thread active bits |
| req_addr | input | NTHR*32 | Per-thread byte addresses, thread 0 in the low bits |
| req_esize | input | 3 | Element-size code (0..4 for 1..16 bytes) |
| txn_valid | output | 1 | Transaction available |
| txn_ready | input | 1 | Transaction taken |
| txn_base | output | 32 | Aligned transaction base address |
| txn_bytes | output | 8 | Transaction size in bytes (32, 64 or 128) |
| txn_mask | output | NTHR | Threads served by this transaction |
| done | output | 1 | One-cycle pulse when the request is finished |

## Verification
The assertions assume a few things about the inputs. The element-size code stays within 0 to 4. Addresses do not sit so close to the top of the address space that a footprint wraps. `txn_ready` may change freely in any cycle. The stimulus picks its codes only from the legal set and its bases from a low window of the address space. It drives `txn_ready` from a pseudo-random bit, so stalls land at arbitrary points in a transaction list. Across the sweep, addresses are contiguous, reversed, strided, confined to an upper half, random and deliberately misaligned. The misaligned addresses exercise footprints that straddle window halves.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

    localparam int ADDR_W  = 32;
    localparam int BYTES_W = 8;

    typedef enum logic { ST_IDLE, ST_BUSY } hwc_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0]  base;
        logic [BYTES_W-1:0] bytes;
    } hwc_txn_t;

    // log2 of the segment size chosen by the element-size code
    function automatic logic [2:0] seg_log2(input logic [2:0] esize);
        case (esize)
            3'd0:    return 3'd5;
            3'd1:    return 3'd6;
            default: return 3'd7;
        endcase
    endfunction

    // element byte count; illegal codes clamp to the widest element
    function automatic logic [4:0] elem_bytes(input logic [2:0] esize);
        if (esize > 3'd4) return 5'd16;
        return 5'd1 << esize;
    endfunction

endpackage

// File: rtl/hwc_pick_lowest.sv
module hwc_pick_lowest #(
    parameter int N  = 16,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |req;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/hwc_txn_shape.sv
module hwc_txn_shape
    import hwc_pkg::*;
#(
    parameter int NTHR = 16,
    localparam int IW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic [NTHR-1:0]             pend,
    input  logic [NTHR-1:0][ADDR_W-1:0] addr,
    input  logic [2:0]                  esize,
    input  logic [IW-1:0]               lead,
    output hwc_txn_t                    txn,
    output logic [NTHR-1:0]             mask
);
    logic [2:0]        seg_lg;
    logic [ADDR_W-1:0] low_bits;
    logic [ADDR_W-1:0] seg_base;
    logic [7:0]        ebytes;
    logic [NTHR-1:0][7:0] off;
    logic [NTHR-1:0][7:0] fend;

    // segment membership and per-thread footprint offsets
    always_comb begin
        seg_lg   = seg_log2(esize);
        low_bits = (ADDR_W'(1) << seg_lg) - ADDR_W'(1);
        seg_base = addr[lead] & ~low_bits;
        ebytes   = 8'(elem_bytes(esize));
        for (int i = 0; i < NTHR; i++) begin
            mask[i] = pend[i] && ((addr[i] & ~low_bits) == seg_base);
            off[i]  = {1'b0, addr[i][6:0] & low_bits[6:0]};
            fend[i] = off[i] + ebytes - 8'd1;
        end
    end

    // up to two halving steps toward a 32-byte window
    logic [2:0] wlg;
    logic [7:0] woff;
    logic [7:0] half;
    logic       lo_use;
    logic       hi_use;

    always_comb begin
        wlg    = seg_lg;
        woff   = '0;
        half   = '0;
        lo_use = 1'b0;
        hi_use = 1'b0;
        for (int s = 0; s < 2; s++) begin
            if (wlg > 3'd5) begin
                half   = 8'd1 << (wlg - 3'd1);
                lo_use = 1'b0;
                hi_use = 1'b0;
                for (int i = 0; i < NTHR; i++) begin
                    if (mask[i]) begin
                        if (off[i] < woff + half)   lo_use = 1'b1;
                        if (fend[i] >= woff + half) hi_use = 1'b1;
                    end
                end
                if (!(lo_use && hi_use)) begin
                    if (hi_use) woff = woff + half;
                    wlg = wlg - 3'd1;
                end
            end
        end
        txn.base  = seg_base | ADDR_W'(woff);
        txn.bytes = 8'd1 << wlg;
    end
endmodule

// File: rtl/halfwarp_coalescer.sv
module halfwarp_coalescer
    import hwc_pkg::*;
#(
    parameter int NTHR = 16,
    localparam int IW  = (NTHR > 1) ? $clog2(NTHR) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [NTHR-1:0]          req_active,
    input  logic [NTHR*ADDR_W-1:0]   req_addr,
    input  logic [2:0]               req_esize,
    output logic                     txn_valid,
    input  logic                     txn_ready,
    output logic [ADDR_W-1:0]        txn_base,
    output logic [BYTES_W-1:0]       txn_bytes,
    output logic [NTHR-1:0]          txn_mask,
    output logic                     done
);
    hwc_state_t                  state_q;
    logic [NTHR-1:0]             pend_q;
    logic [NTHR-1:0][ADDR_W-1:0] addr_q;
    logic [2:0]                  esize_q;
    logic                        done_q;

    logic [IW-1:0] lead;
    logic          any_pend;
    hwc_txn_t      shape;
    logic [NTHR-1:0] served;

    hwc_pick_lowest #(.N(NTHR)) pick_i (
        .req (pend_q),
        .idx (lead),
        .any (any_pend)
    );

    hwc_txn_shape #(.NTHR(NTHR)) shape_i (
        .pend  (pend_q),
        .addr  (addr_q),
        .esize (esize_q),
        .lead  (lead),
        .txn   (shape),
        .mask  (served)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign txn_valid = (state_q == ST_BUSY) && any_pend;
    assign txn_base  = shape.base;
    assign txn_bytes = shape.bytes;
    assign txn_mask  = served;
    assign done      = done_q;

    logic req_fire;
    logic txn_fire;
    assign req_fire = req_valid && req_ready;
    assign txn_fire = txn_valid && txn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pend_q  <= '0;
            addr_q  <= '0;
            esize_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (req_fire) begin
                pend_q  <= req_active;
                addr_q  <= req_addr;
                esize_q <= req_esize;
                if (req_active == '0) done_q  <= 1'b1;
                else                  state_q <= ST_BUSY;
            end else if (txn_fire) begin
                pend_q <= pend_q & ~served;
                if ((pend_q & ~served) == '0) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end
            end
        end
    end

    AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_base) && $stable(txn_bytes) && $stable(txn_mask)); // R9
    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> $onehot(txn_bytes) && txn_bytes >= 8'd32 && txn_bytes <= 8'd128); // R1
    AST_SIZE_WITHIN_SEGMENT: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> txn_bytes <= (8'd1 << seg_log2(esize_q))); // R1
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> (txn_base & (ADDR_W'(txn_bytes) - ADDR_W'(1))) == '0); // R2
    AST_MASK_SUBSET: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> txn_mask != '0 && (txn_mask & ~pend_q) == '0); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> !req_ready); // R10
    AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(txn_fire && (pend_q & ~served) == '0) || $past(req_fire && req_active == '0)); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done || $past(req_fire && req_active == '0)); // R8
endmodule

// File: tb/halfwarp_coalescer_tb.sv
module halfwarp_coalescer_tb_top;
    localparam int NTHR = 16;
    localparam int AW   = 32;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               req_valid = 1'b0;
    logic               req_ready;
    logic [NTHR-1:0]    req_active = '0;
    logic [NTHR*AW-1:0] req_addr = '0;
    logic [2:0]         req_esize = '0;
    logic               txn_valid;
    logic               txn_ready = 1'b0;
    logic [AW-1:0]      txn_base;
    logic [7:0]         txn_bytes;
    logic [NTHR-1:0]    txn_mask;
    logic               done;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] rng = 32'h1ace_b00c;

    always #4 clk = ~clk;

    halfwarp_coalescer #(.NTHR(NTHR)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_active(req_active), .req_addr(req_addr), .req_esize(req_esize),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_bytes(txn_bytes), .txn_mask(txn_mask),
        .done(done)
    );

    function automatic logic [31:0] step(input logic [31:0] x);
        logic [31:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // expected transaction: smallest aligned window (not below 32 bytes) around
    // the leader that holds every member footprint, clipped to the segment
    task automatic expect_txn(input logic [NTHR-1:0] pend, input logic [31:0] a [NTHR],
                              input int esz, output logic [31:0] ebase,
                              output int ebytes, output logic [NTHR-1:0] emask);
        int lead = -1;
        int seg  = (esz == 0) ? 32 : (esz == 1) ? 64 : 128;
        int eb   = 1 << esz;
        logic [31:0] sb;
        for (int i = NTHR - 1; i >= 0; i--) if (pend[i]) lead = i;
        sb = a[lead] - (a[lead] % seg);
        emask = '0;
        for (int i = 0; i < NTHR; i++)
            if (pend[i] && (a[i] / seg) == (sb / seg)) emask[i] = 1'b1;
        ebytes = seg;
        ebase  = sb;
        for (int w = 32; w <= seg; w = w * 2) begin
            int ws = int'((a[lead] - sb) / w) * w;
            bit ok = 1'b1;
            for (int i = 0; i < NTHR; i++) begin
                if (emask[i]) begin
                    int o = int'(a[i] - sb);
                    int e = o + eb - 1;
                    if (e > seg - 1) e = seg - 1;
                    if (o < ws || e > ws + w - 1) ok = 1'b0;
                end
            end
            if (ok && ebytes == seg && w < seg) begin
                ebytes = w;
                ebase  = sb + ws;
            end
            if (ok && w < seg) break;
        end
    endtask

    task automatic run_req(input logic [NTHR-1:0] act, input logic [31:0] a [NTHR], input int esz);
        logic [NTHR-1:0] pend = act;
        logic [31:0] ebase, pbase;
        int ebytes;
        logic [NTHR-1:0] emask, pmask;
        logic [7:0] pbytes;
        bit stalled = 1'b0;
        int guard = 0;
        @(negedge clk);
        req_valid  = 1'b1;
        req_active = act;
        req_esize  = 3'(esz);
        for (int i = 0; i < NTHR; i++) req_addr[i*AW +: AW] = a[i];
        chk("R10 ready when idle", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (act == '0) begin
            chk("R8 empty request done", 64'(done), 64'd1);
            chk("R8 empty request no txn", 64'(txn_valid), 64'd0);
            @(negedge clk);
            chk("R8 done single pulse", 64'(done), 64'd0);
            return;
        end
        // offer a request while busy: it must not be taken
        req_valid  = 1'b1;
        req_active = '1;
        while (pend != '0 && guard < 64) begin
            guard++;
            chk("R10 not ready while busy", 64'(req_ready), 64'd0);
            chk("R7 valid while threads wait", 64'(txn_valid), 64'd1);
            if (stalled) begin
                chk("R9 base held", 64'(txn_base), 64'(pbase));
                chk("R9 size held", 64'(txn_bytes), 64'(pbytes));
                chk("R9 mask held", 64'(txn_mask), 64'(pmask));
            end
            expect_txn(pend, a, esz, ebase, ebytes, emask);
            chk("R3 served mask", 64'(txn_mask), 64'(emask));
            chk("R2 R4 R5 base", 64'(txn_base), 64'(ebase));
            chk("R1 R4 R5 R6 size", 64'(txn_bytes), 64'(ebytes));
            chk("R7 no early done", 64'(done), 64'd0);
            rng = step(rng);
            txn_ready = rng[3];
            pbase = txn_base; pbytes = txn_bytes; pmask = txn_mask;
            stalled = !txn_ready;
            if (txn_ready) pend = pend & ~emask;
            @(negedge clk);
        end
        req_valid = 1'b0;
        txn_ready = 1'b0;
        chk("R7 done after last", 64'(done), 64'd1);
        chk("R7 no txn after last", 64'(txn_valid), 64'd0);
        @(negedge clk);
        chk("R7 done single pulse", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] a [NTHR];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset ready", 64'(req_ready), 64'd1);
        chk("R7 reset no txn", 64'(txn_valid), 64'd0);
        chk("R7 reset no done", 64'(done), 64'd0);
        for (int esz = 0; esz <= 4; esz++) begin
            for (int kind = 0; kind < 8; kind++) begin
                for (int rep = 0; rep < 4; rep++) begin
                    logic [NTHR-1:0] act;
                    logic [31:0] base;
                    int eb = 1 << esz;
                    rng = step(rng);
                    base = {rng[15:0], 7'd0} & 32'h00ff_ff80;
                    rng = step(rng);
                    act = (rep == 0) ? '1 : rng[NTHR-1:0];
                    for (int i = 0; i < NTHR; i++) begin
                        rng = step(rng);
                        case (kind)
                            0: a[i] = base + 32'(i * eb);
                            1: a[i] = base + 32'((NTHR - 1 - i) * eb);
                            2: a[i] = base + 32'(i * 32 * (rep + 1));
                            3: a[i] = base + 32'd64 + 32'((i * eb) % 64);
                            4: a[i] = base + 32'(((rng[7:0] % 256) / eb) * eb);
                            5: a[i] = base + 32'(rng[8:0]);
                            6: a[i] = base + 32'd32 + 32'((i * eb) % 32);
                            default: a[i] = base;
                        endcase
                    end
                    if (kind == 7) act = '0;
                    run_req(act, a, esz);
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule